// File: doc/BRIEF.md
# Programmable Timer Counter Channel

A single down-counting timer channel of parameterised width (16 bits by default). A one-cycle enable marks each timer-clock tick. Software-side logic outside the block supplies a reload value and a 3-bit operating mode, each with a write strobe, and a board-level gate signal. From these the channel produces a single output waveform and a live count value. Neighbouring bus logic uses the live count and the output level for count latching and status read-back.

Six behaviours are selectable:
- terminal-count event
- retriggerable one-shot
- rate generator
- square wave
- software strobe
- hardware strobe

A reload value of zero stands for the full 2^W span. Writing a new mode stops the channel. It then waits, with an idle output level, until a count is loaded. Loading a count starts counting from the reload value. In the retriggerable modes a rising gate edge restarts the sequence.

Top module: `timer_channel`

## Requirements
- R1: A reload value of 0 is taken as a period of 65536 ticks: the live count reads 0 right after the load, and the terminal event comes 65536 ticks later.
- R2: A load strobe restarts counting from the new value: on the following cycle the live count equals the written value, and the elapsed-tick count is zero.
- R3: In mode 0 (terminal-count event) and mode 1 (one-shot), the output is low after a load. It goes high when the elapsed ticks reach the reload value N, and stays high.
- R4: In mode 2 (rate generator), the output is high except for one tick period of low at every multiple of N elapsed ticks (not at zero).
- R5: In mode 3 (square wave), within each period of N ticks the output is high for the first (N+1)/2 ticks (rounded down) and low for the rest.
- R6: In mode 4 (software strobe) and mode 5 (hardware strobe), the output is low for exactly one tick period when the elapsed ticks equal N, and high at all other times.
- R7: In modes 1, 2, 3 and 5, a rising gate edge on a loaded channel restarts counting from N. The tick in that cycle is not counted.
- R8: In modes 2 and 3 a low gate freezes the count and the output. In modes 0 and 4 the gate level and gate edges have no effect.
- R9: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R10: After reset the channel is in mode 3 with a reload of 0 (65536). It is counting, with the output high and the live count 0. The gate edge detector starts from the level set by the GATE_INIT parameter.
- R11: A mode write stops counting and shows the current reload value on the live count. Until the next load, the output is low for mode 0 and high for any other mode.
- R12: Without a tick, load, mode write or restarting gate edge, the count and output hold.
- R13: In modes 2 and 3 the live count is N minus the elapsed ticks within the current period. In modes 0, 1, 4 and 5 it is N minus the elapsed ticks modulo 65536, so it wraps through 0xFFFF after the terminal event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer-clock enable, one tick per high cycle |
| load_stb | input | 1 | Load reload_val and restart counting |
| reload_val | input | CNT_W | Reload value, 0 means 2^CNT_W |
| mode_stb | input | 1 | Write mode_sel and stop counting |
| mode_sel | input | 3 | Operating mode code |
| gate_in | input | 1 | Gate level |
| count_o | output | CNT_W | Live count, registered |
| out_o | output | 1 | Channel output, registered |

## Verification
A bad count register or a wrong wrap point shows on count_o on the first tick after the fault. It shows on out_o at the next period boundary or half-period point, which is at most N ticks later. A terminal flag or strobe flag that is stuck or never clears shows on out_o either for the whole run or for one tick period too long. A stray restart on a gate edge shows on the very next cycle as the live count jumping back to N. The bench therefore compares both outputs with a reference model on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MD_TC_EVENT  = 3'd0,
    MD_ONESHOT   = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } tmr_mode_e;

  // Codes 6 and 7 alias the periodic modes 2 and 3.
  function automatic tmr_mode_e fold_mode(logic [2:0] m);
    if (m[2] & m[1]) return tmr_mode_e'({1'b0, m[1:0]});
    return tmr_mode_e'(m);
  endfunction

  function automatic logic is_periodic(tmr_mode_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

  function automatic logic gate_retrig(tmr_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) ||
           (m == MD_SQUARE)  || (m == MD_HW_STROBE);
  endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge #(
  parameter bit GATE_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= GATE_INIT;
    else     gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  input  logic         mode_wr_i,
  input  logic [2:0]   mode_i,
  input  logic         gate_i,
  input  logic         rise_i,
  output logic [W:0]   nx_cnt,
  output logic [W:0]   nx_n,
  output logic [2:0]   nx_mode,
  output logic         nx_armed,
  output logic         nx_tc,
  output logic         nx_pulse,
  output logic [W-1:0] count_o
);
  localparam int         NW   = W + 1;
  localparam logic [NW-1:0] FULL = NW'(1) << W;
  localparam logic [NW-1:0] ONE  = NW'(1);
  localparam logic [NW-1:0] WRAP = FULL - ONE;

  logic [NW-1:0] cnt_q, n_q;
  logic [2:0]    mode_q;
  logic          armed_q, tc_q, pulse_q;
  tmr_mode_e     em;

  assign em = fold_mode(mode_q);

  always_comb begin
    nx_cnt   = cnt_q;
    nx_n     = n_q;
    nx_mode  = mode_q;
    nx_armed = armed_q;
    nx_tc    = tc_q;
    nx_pulse = pulse_q;
    if (mode_wr_i) begin
      nx_mode  = mode_i;
      nx_armed = 1'b0;
      nx_cnt   = n_q;
      nx_tc    = 1'b0;
      nx_pulse = 1'b0;
    end else if (load_i) begin
      nx_n     = (reload_i == '0) ? FULL : {1'b0, reload_i};
      nx_cnt   = nx_n;
      nx_armed = 1'b1;
      nx_tc    = 1'b0;
      nx_pulse = 1'b0;
    end else if (armed_q && rise_i && gate_retrig(em)) begin
      nx_cnt   = n_q;
      nx_tc    = 1'b0;
      nx_pulse = 1'b0;
    end else if (armed_q && tick_i && (!is_periodic(em) || gate_i)) begin
      if (is_periodic(em)) begin
        nx_pulse = (cnt_q == ONE);
        nx_cnt   = (cnt_q == ONE) ? n_q : cnt_q - ONE;
      end else begin
        nx_pulse = (cnt_q == ONE) && !tc_q;
        nx_tc    = tc_q | (cnt_q == ONE);
        nx_cnt   = (cnt_q == '0) ? WRAP : cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= FULL;
      n_q     <= FULL;
      mode_q  <= 3'd3;
      armed_q <= 1'b1;
      tc_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= nx_cnt;
      n_q     <= nx_n;
      mode_q  <= nx_mode;
      armed_q <= nx_armed;
      tc_q    <= nx_tc;
      pulse_q <= nx_pulse;
    end
  end

  assign count_o = cnt_q[W-1:0];

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load_i && !mode_wr_i |=> count_o == $past(reload_i)); // R2

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i && !load_i && !mode_wr_i && !rise_i |=> $stable(cnt_q)); // R12

  AST_GATE_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    armed_q && is_periodic(em) && !gate_i && !load_i && !mode_wr_i
    |=> $stable(cnt_q) && $stable(pulse_q)); // R8

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    armed_q && pulse_q && tick_i && !is_periodic(em) && !load_i && !mode_wr_i
    |=> !pulse_q); // R6

  AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed_q && tc_q && !is_periodic(em) && !load_i && !mode_wr_i && !rise_i
    |=> tc_q); // R3

endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_i,
  input  logic       armed_i,
  input  logic       tc_i,
  input  logic       pulse_i,
  input  logic [W:0] cnt_i,
  input  logic [W:0] n_i,
  output logic       out_o
);
  localparam int NW = W + 1;

  logic [NW-1:0] half, thr;
  logic          out_n;
  tmr_mode_e     em;

  assign em   = fold_mode(mode_i);
  assign half = {1'b0, n_i[NW-1:1]} + NW'(n_i[0]);
  assign thr  = n_i - half;

  always_comb begin
    if (!armed_i) out_n = (mode_i != 3'd0);
    else begin
      unique case (em)
        MD_TC_EVENT, MD_ONESHOT:    out_n = tc_i;
        MD_RATE:                    out_n = !pulse_i;
        MD_SQUARE:                  out_n = (cnt_i > thr);
        MD_SW_STROBE, MD_HW_STROBE: out_n = !pulse_i;
        default:                    out_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_o <= 1'b1;
    else     out_o <= out_n;
  end

endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CNT_W     = 16,
  parameter bit GATE_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             mode_stb,
  input  logic [2:0]       mode_sel,
  input  logic             gate_in,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic             rise;
  logic [CNT_W:0]   nx_cnt, nx_n;
  logic [2:0]       nx_mode;
  logic             nx_armed, nx_tc, nx_pulse;

  tmr_gate_edge #(.GATE_INIT(GATE_INIT)) u_gate (
    .clk(clk), .rst(rst), .gate_i(gate_in), .rise_o(rise)
  );

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick_i(tick_en), .load_i(load_stb),
    .reload_i(reload_val), .mode_wr_i(mode_stb), .mode_i(mode_sel),
    .gate_i(gate_in), .rise_i(rise),
    .nx_cnt(nx_cnt), .nx_n(nx_n), .nx_mode(nx_mode), .nx_armed(nx_armed),
    .nx_tc(nx_tc), .nx_pulse(nx_pulse), .count_o(count_o)
  );

  tmr_wave_gen #(.W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .mode_i(nx_mode), .armed_i(nx_armed),
    .tc_i(nx_tc), .pulse_i(nx_pulse), .cnt_i(nx_cnt), .n_i(nx_n),
    .out_o(out_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_o && (count_o == '0)); // R10

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    mode_stb |=> out_o == ($past(mode_sel) != 3'd0)); // R11

  AST_FULL_SPAN: assert property (@(posedge clk) disable iff (rst)
    load_stb && !mode_stb && (reload_val == '0) |=> count_o == '0); // R1

endmodule

// File: tb/timer_channel_test.sv
`timescale 1ns/1ps
module timer_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, load_stb = 1'b0, mode_stb = 1'b0, gate_in = 1'b1;
  logic [15:0] reload_val = '0;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] count_o;
  logic        out_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R10";

  // reference model state
  int m_mode = 3, m_n = 65536, m_d = 0;
  bit m_armed = 1, m_gprev = 1;

  always #2.5 clk = ~clk;

  timer_channel #(.CNT_W(16), .GATE_INIT(1'b1)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load_stb(load_stb),
    .reload_val(reload_val), .mode_stb(mode_stb), .mode_sel(mode_sel),
    .gate_in(gate_in), .count_o(count_o), .out_o(out_o)
  );

  function automatic int fold(int m);
    return (m >= 6) ? m - 4 : m;
  endfunction

  function automatic int exp_count();
    int em = fold(m_mode);
    if (em == 2 || em == 3) return (m_n - (m_d % m_n)) % 65536;
    return (((m_n - m_d) % 65536) + 65536) % 65536;
  endfunction

  function automatic bit exp_out();
    int em = fold(m_mode);
    int ph = m_d % m_n;
    if (!m_armed) return (m_mode != 0);
    case (em)
      0, 1:    return m_d >= m_n;
      2:       return !(ph == 0 && m_d != 0);
      3:       return ph < (m_n + 1) / 2;
      default: return m_d != m_n;
    endcase
  endfunction

  task automatic model_step();
    int  em = fold(m_mode);
    bit  rise;
    if (rst) begin
      m_mode = 3; m_n = 65536; m_d = 0; m_armed = 1; m_gprev = 1;
      return;
    end
    rise = gate_in && !m_gprev;
    m_gprev = gate_in;
    if (mode_stb) begin
      m_mode = mode_sel; m_armed = 0; m_d = 0;
    end else if (load_stb) begin
      m_n = (reload_val == 0) ? 65536 : reload_val; m_d = 0; m_armed = 1;
    end else if (m_armed && rise && (em == 1 || em == 2 || em == 3 || em == 5)) begin
      m_d = 0;
    end else if (m_armed && tick_en && (!(em == 2 || em == 3) || gate_in)) begin
      m_d++;
    end
  endtask

  task automatic compare();
    int  ec = exp_count();
    bit  eo = exp_out();
    checks += 2;
    if (count_o !== 16'(ec)) begin
      fails++;
      $display("FAIL %s count act=%h exp=%h", req, count_o, 16'(ec));
    end
    if (out_o !== eo) begin
      fails++;
      $display("FAIL %s out act=%b exp=%b", req, out_o, eo);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n, int every);
    for (int i = 0; i < n; i++) begin
      tick_en = ((i % every) == 0);
      cyc();
    end
    tick_en = 1'b0;
  endtask

  task automatic set_mode(int m);
    mode_sel = 3'(m); mode_stb = 1'b1; cyc(); mode_stb = 1'b0;
  endtask

  task automatic load(int v);
    reload_val = 16'(v); load_stb = 1'b1; cyc(); load_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    req = "R10"; cyc(); cyc(); cyc();
    rst = 1'b0;
    cyc();
    run(12, 1);                          // default mode 3, full span
    req = "R11"; set_mode(0); run(3, 1); // idle low, ticks ignored
    set_mode(4); run(3, 1);              // idle high
    req = "R3"; set_mode(0); load(5); run(10, 1);
    req = "R12"; load(4); run(14, 3);
    req = "R13"; load(2); run(6, 1);
    req = "R8"; gate_in = 0; run(2, 1); gate_in = 1; run(3, 1); // mode 0 ignores gate
    req = "R3"; set_mode(1); load(4); run(2, 1);
    req = "R7"; gate_in = 0; cyc(); gate_in = 1; tick_en = 1; cyc(); run(8, 1);
    req = "R4"; set_mode(2); load(3); run(12, 1);
    req = "R8"; gate_in = 0; run(4, 1);
    req = "R7"; gate_in = 1; tick_en = 1; cyc(); run(9, 2);
    req = "R5"; set_mode(3); load(5); run(16, 1); load(4); run(13, 1);
    req = "R8"; gate_in = 0; run(3, 1);
    req = "R7"; gate_in = 1; run(6, 1);
    req = "R6"; set_mode(4); load(3); run(3, 1);
    req = "R8"; gate_in = 0; cyc(); gate_in = 1; run(6, 1);
    req = "R6"; set_mode(5); load(2); run(5, 1);
    req = "R7"; gate_in = 0; cyc(); gate_in = 1; run(5, 1);
    req = "R9"; set_mode(6); load(3); run(10, 1);
    set_mode(7); load(5); run(12, 1); gate_in = 0; run(2, 1); gate_in = 1; run(4, 1);
    req = "R2"; set_mode(2); load(7); run(3, 1); load(2); run(5, 1);
    req = "R1"; load(0); run(65540, 1);
    set_mode(0); load(0); run(3, 1);
    finish_run();
  end
endmodule